// File: doc/BRIEF.md
# Bit-Serial Four-Tap Dot-Product Engine

This block forms the dot product of four signed samples with four constant weights without any parallel multiplier. A single start pulse captures four 8-bit two's-complement samples. The engine then walks through the sample bits one position per clock, most significant first. Each cycle it gathers the current bit of every sample into a 4-bit index and looks up a precomputed sum of weights in a 16-entry table. It doubles its running total and adds the looked-up value. On the sign-bit cycle it subtracts the value instead.

The weights are fixed at elaboration. They are given as integer (already quantised) coefficients, and the table is built from them at that time. After the eighth step the full-precision result is registered and a one-cycle done strobe is raised. Typical use is as the arithmetic kernel of one output term of an 8-point transform stage, where the caller pre-combines sample pairs and feeds the four sums here.

Top module: `da_dot_unit`

## Requirements
- R1: After reset, done_o is 0 and result_o is 0.
- R2: When start_i is sampled high at a rising edge while the engine is idle, done_o is high after the eighth following rising edge, and low after every edge in between.
- R3: The registered result equals W0*x0 + W1*x1 + W2*x2 + W3*x3. Sample xi is the signed 8-bit field opnd_i[8i+7:8i]. The default weights are W0=1606, W1=-1362, W2=910, W3=-319.
- R4: The result is exact, with no wrap, at the extremes: all samples -128 and all samples +127, for any mix of weight signs.
- R5: A start_i pulse that arrives while a computation is in progress is ignored. Neither the timing of that computation's done_o nor its result changes.
- R6: done_o is high for exactly one cycle per computation. result_o changes only on the cycle in which done_o goes high, and it holds its value otherwise.
- R7: Lookup entry k is the sum of the weights Wi for which bit i of k is set, and it fits the 16-bit entry width. A sample vector with only xi = 1 yields exactly Wi.
- R8: The sign-bit step subtracts its table value. A vector with only xi = -128 yields -128*Wi, and a vector with only xi = -1 yields -Wi.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture samples and begin; ignored while busy |
| opnd_i | input | 32 | Four packed signed samples, tap i at bits [8i+7:8i] |
| done_o | output | 1 | One-cycle strobe marking a fresh result |
| result_o | output | 24 | Signed dot product, held until the next completion |

## Verification
The checker assumes that start_i may arrive on any cycle, including while a computation runs and in the cycle that done_o is high. It assumes nothing about the sample values. Its cycle counter restarts only on a start that the idle engine accepts. The stimulus mixes directed extremes and single-tap vectors with random sample vectors drawn from a fixed seed. In some runs a second start pulse is injected mid-computation, and in others a new start follows the done strobe at once, so that both the accepted path and the ignored path stay inside those assumptions.

// File: rtl/da_dot_pkg.sv
package da_dot_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } da_state_e;

   function automatic int unsigned cnt_width(input int unsigned steps);
      return (steps <= 1) ? 1 : $clog2(steps);
   endfunction
endpackage

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
   parameter int N_TAPS  = 4,
   parameter int ENTRY_W = 16,
   parameter int COEFS [N_TAPS] = '{1606, -1362, 910, -319}
) (
   input  logic [N_TAPS-1:0]         addr_i,
   output logic signed [ENTRY_W-1:0] data_o
);
   localparam int DEPTH = 1 << N_TAPS;
   localparam int MAX_V = (1 << (ENTRY_W - 1)) - 1;
   localparam int MIN_V = -(1 << (ENTRY_W - 1));

   function automatic int subset_sum(input int idx);
      int s;
      s = 0;
      for (int i = 0; i < N_TAPS; i++) begin
         if (idx[i]) s += COEFS[i];
      end
      return s;
   endfunction

   logic signed [ENTRY_W-1:0] table_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      localparam int VAL = subset_sum(e);
      if (VAL > MAX_V || VAL < MIN_V) begin : g_range_err
         $error("table entry %0d does not fit entry width", e);
      end
      assign table_q[e] = ENTRY_W'(VAL);
   end

   assign data_o = table_q[addr_i];
endmodule

// File: rtl/da_bit_slicer.sv
module da_bit_slicer #(
   parameter int N_TAPS = 4,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic                     step_i,
   input  logic [N_TAPS*DATA_W-1:0] opnd_i,
   output logic [N_TAPS-1:0]        addr_o
);
   for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
      logic [DATA_W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (load_i) begin
            sh_q <= opnd_i[t*DATA_W +: DATA_W];
         end else if (step_i) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
         end
      end
      assign addr_o[t] = sh_q[DATA_W-1];
   end
endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
   import da_dot_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic sign_o,
   output logic finish_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = cnt_width(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   da_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign busy_o   = (state_q == ST_RUN);
   assign load_o   = start_i && !busy_o;
   assign step_o   = busy_o;
   assign sign_o   = busy_o && (cnt_q == '0);
   assign finish_o = busy_o && (cnt_q == LAST);
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish_o;
         unique case (state_q)
            ST_IDLE: begin
               if (load_o) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (finish_o) begin
                  state_q <= ST_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/da_accum.sv
module da_accum #(
   parameter int ENTRY_W = 16,
   parameter int ACC_W   = 24
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic                      step_i,
   input  logic                      sign_i,
   input  logic                      finish_i,
   input  logic signed [ENTRY_W-1:0] entry_i,
   output logic signed [ACC_W-1:0]   result_o
);
   logic signed [ACC_W-1:0] acc_q, acc_next, entry_ext, acc_dbl;

   assign entry_ext = ACC_W'(entry_i);
   assign acc_dbl   = acc_q <<< 1;
   assign acc_next  = sign_i ? (acc_dbl - entry_ext) : (acc_dbl + entry_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         result_o <= '0;
      end else begin
         if (load_i) begin
            acc_q <= '0;
         end else if (step_i) begin
            acc_q <= acc_next;
         end
         if (finish_i) begin
            result_o <= acc_next;
         end
      end
   end
endmodule

// File: rtl/da_dot_unit.sv
module da_dot_unit #(
   parameter int N_TAPS  = 4,
   parameter int DATA_W  = 8,
   parameter int ENTRY_W = 16,
   parameter int ACC_W   = 24,
   parameter int COEFS [N_TAPS] = '{1606, -1362, 910, -319}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [N_TAPS*DATA_W-1:0]   opnd_i,
   output logic                       done_o,
   output logic signed [ACC_W-1:0]    result_o
);
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (N_TAPS < 1 || N_TAPS > 8) begin : g_bad_taps
      $error("N_TAPS must lie in 1..8");
   end
   if (ACC_W < ENTRY_W + DATA_W) begin : g_bad_acc
      $error("ACC_W too narrow for DATA_W doublings of an entry");
   end

   logic              load, step, sign, finish, busy;
   logic [N_TAPS-1:0] addr;
   logic signed [ENTRY_W-1:0] entry;

   da_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .load_o(load), .step_o(step), .sign_o(sign),
      .finish_o(finish), .busy_o(busy), .done_o(done_o)
   );

   da_bit_slicer #(.N_TAPS(N_TAPS), .DATA_W(DATA_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .opnd_i(opnd_i), .addr_o(addr)
   );

   da_coef_rom #(.N_TAPS(N_TAPS), .ENTRY_W(ENTRY_W), .COEFS(COEFS)) u_rom (
      .addr_i(addr), .data_o(entry)
   );

   da_accum #(.ENTRY_W(ENTRY_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .sign_i(sign), .finish_i(finish), .entry_i(entry),
      .result_o(result_o)
   );
endmodule

// File: rtl/da_dot_checker.sv
module da_dot_checker #(
   parameter int DATA_W = 8,
   parameter int ACC_W  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy,
   input logic             done_o,
   input logic [ACC_W-1:0] result_o
);
   localparam int FIN = DATA_W + 1;
   int unsigned cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_q <= 0;
      else if (start_i && !busy) cyc_q <= 1;
      else if (cyc_q != 0 && cyc_q < FIN) cyc_q <= cyc_q + 1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 0) |-> !done_o);

   a_r2_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cyc_q == FIN && !busy));

   a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && cyc_q < DATA_W) |=> busy);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
endmodule

bind da_dot_unit da_dot_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
   .done_o(done_o), .result_o(result_o)
);

// File: tb/da_dot_unit_tb.sv
module da_dot_unit_tb;
   localparam int W [4] = '{1606, -1362, 910, -319};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] opnd_i = '0;
   logic        done_o;
   logic signed [23:0] result_o;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cycles++;

   da_dot_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opnd_i(opnd_i),
      .done_o(done_o), .result_o(result_o)
   );

   function automatic int expect_dot(input logic [31:0] v);
      int s = 0;
      for (int i = 0; i < 4; i++) s += W[i] * int'($signed(v[i*8 +: 8]));
      return s;
   endfunction

   function automatic logic [31:0] pack4(input int a, input int b, input int c, input int d);
      return {8'(d), 8'(c), 8'(b), 8'(a)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Runs one computation. intrude>0 pulses start again that many cycles in.
   // Entered and left at a negedge.
   task automatic run(input string req, input logic [31:0] v, input int intrude);
      int exp_v = expect_dot(v);
      start_i = 1'b1;
      opnd_i  = v;
      @(negedge clk);
      start_i = 1'b0;
      opnd_i  = ~v;
      for (int c = 1; c <= 8; c++) begin
         if (c < 8) check({req, " R2 no early done"}, int'(done_o), 0);
         if (intrude == c) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      check({req, " R2/R6 done after eight"}, int'(done_o), 1);
      check(req, int'(result_o), exp_v);
      @(negedge clk);
      check({req, " R6 single pulse"}, int'(done_o), 0);
      check({req, " R6 result held"}, int'(result_o), exp_v);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0d07));
      @(negedge clk);
      @(negedge clk);
      check("R1 done at reset", int'(done_o), 0);
      check("R1 result at reset", int'(result_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after release", int'(done_o), 0);

      run("R3 mixed", pack4(12, -7, 100, -55), 0);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] one = 32'(1) << (8 * i);
         logic [31:0] mn  = 32'h80 << (8 * i);
         logic [31:0] m1  = 32'hff << (8 * i);
         run("R7 single tap one", one, 0);
         run("R8 single tap min", mn, 0);
         run("R8 single tap minus one", m1, 0);
      end
      run("R4 all min", 32'h8080_8080, 0);
      run("R4 all max", 32'h7f7f_7f7f, 0);
      run("R4 signs against weights", pack4(127, -128, 127, -128), 0);
      run("R4 signs with weights", pack4(-128, 127, -128, 127), 0);
      run("R3 zero", 32'h0, 0);

      run("R5 intrude early", pack4(33, 44, -55, 66), 1);
      run("R5 intrude late", pack4(-1, 2, -3, 4), 7);
      run("R5 intrude mid", pack4(90, -90, 45, -45), 4);

      for (int n = 0; n < 40; n++) begin
         logic [31:0] v = $urandom;
         int gap = $urandom_range(0, 2);
         int intr = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
         run("R3 random", v, intr);
         for (int g = 0; g < gap; g++) @(negedge clk);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule